// File: doc/BRIEF.md
# Doubly Linked Sharing-List Coherence Engine

This block tracks which of a small group of caches hold a copy of one memory block. The holders are kept as a doubly linked list. The memory side keeps only a cached/uncached flag and a pointer to the first holder (the head). Each cache entry keeps its own position in the list: invalid, head, middle, tail or exclusive. It also keeps a pointer to its successor (the next holder, toward the tail) and to its predecessor (toward the head).

A cache asks to read by pulsing its read request.
- If memory is uncached, memory supplies the line and the requester becomes the only holder.
- If memory is already cached, memory replies with the current head pointer. The requester then sends a cache-to-cache prepend request to that head. The old head links back to the requester, and the requester becomes the new head.

The head can ask to purge. The engine then walks the successor chain and invalidates one sharer per cycle until the tail is gone. The purging cache is left as the exclusive read-write holder. Each transaction ends with a one-cycle done pulse, plus an error flag if the request was not legal.

Top module: `slist_engine`

## Requirements
- R1: After reset the memory flag is uncached (0) and the memory head pointer is null. Every entry state is invalid (code 0) and every pointer is null. A null pointer is encoded as the value N_CACHE, which is 4 by default. State codes are: invalid 0, head 1, middle 2, tail 3, exclusive 4.
- R2: Suppose a read is accepted from an invalid cache while memory is uncached. On the next clock edge that cache becomes head with both pointers null, memory becomes cached with its head pointer set to that cache, and done pulses.
- R3: Suppose a read is accepted from an invalid cache while memory is cached. Then two clock edges after acceptance, all of the following hold:
  - the requester is head, its successor pointer is the old head and its predecessor pointer is null;
  - the old head's predecessor pointer is the requester;
  - the memory head pointer is the requester;
  - done pulses.
- R4: On a prepend, an old head that had a successor becomes middle. An old head that was alone, or exclusive, becomes tail. Its successor pointer is kept, and no other entry changes.
- R5: A read from a cache whose entry is already valid completes with done one edge after acceptance and changes no state or pointer.
- R6: A purge from the head invalidates its sharers one per clock edge, following successor pointers from the head, and sets each invalidated entry's pointers to null. On the edge that removes the tail, the purging cache becomes exclusive with null pointers and done pulses. The first removal happens two edges after acceptance. A head that has no sharers becomes exclusive one edge after acceptance. Memory stays cached, with the purging cache as its head.
- R7: A purge from a cache that is neither head nor exclusive pulses both err and done one edge after acceptance and changes nothing.
- R8: A purge from the exclusive holder pulses done without err one edge after acceptance and changes nothing.
- R9: A request is accepted only while no transaction is in progress. The lowest-numbered cache with any request wins, and for that cache a purge beats a read. All other requests in the accepting cycle, and any request made while busy, are dropped with no effect.
- R10: done and err are single-cycle pulses. At no time is more than one entry head or exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | N_CACHE | Per-cache read request pulse |
| purge_req | input | N_CACHE | Per-cache purge request pulse |
| cache_state | output | 3*N_CACHE | Entry state of each cache, cache i at bits [3i+2:3i] |
| cache_fwd | output | PW*N_CACHE | Successor pointer of each cache, PW = clog2(N_CACHE+1) |
| cache_bwd | output | PW*N_CACHE | Predecessor pointer of each cache |
| mem_cached | output | 1 | Memory-side cached flag |
| mem_head | output | PW | Memory-side head pointer |
| done | output | 1 | One-cycle pulse when a transaction completes |
| err | output | 1 | One-cycle pulse with done on an illegal purge |

## Verification
Reads are issued to uncached memory, to a list with a lone head, to a list with a longer chain and to an exclusive holder. This separates the first-fill path from each demotion case of the old head. Purges are issued by the head of a three-entry list and of a two-entry list, by a tail and by the exclusive holder. These show the walk order and length, the rejection path and the no-op path. Simultaneous requests and requests made while busy show the priority order and that losing requests are dropped. A model in the bench predicts every state and pointer on every cycle.

// File: rtl/slist_pkg.sv
package slist_pkg;

  typedef enum logic [2:0] {
    ST_INV  = 3'd0,
    ST_HEAD = 3'd1,
    ST_MID  = 3'd2,
    ST_TAIL = 3'd3,
    ST_EXCL = 3'd4
  } ent_state_e;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_MKHEAD    = 3'd1,
    OP_PREPENDED = 3'd2,
    OP_INVAL     = 3'd3,
    OP_EXCL      = 3'd4
  } ent_op_e;

  typedef enum logic [2:0] {
    F_IDLE = 3'd0,
    F_RD   = 3'd1,
    F_PREP = 3'd2,
    F_PCHK = 3'd3,
    F_WALK = 3'd4
  } eng_fsm_e;

  // Position an old head takes once a new reader is linked in front of it.
  function automatic ent_state_e demote_on_prepend(ent_state_e cur, logic has_next);
    if (cur == ST_HEAD && has_next) return ST_MID;
    return ST_TAIL;
  endfunction

  // Owner-class states: the ones that are allowed at most once in the list.
  function automatic logic is_owner(ent_state_e s);
    return (s == ST_HEAD) || (s == ST_EXCL);
  endfunction

endpackage

// File: rtl/slist_arb.sv
module slist_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  rd,
  input  logic [N-1:0]  pg,
  output logic          any,
  output logic [IW-1:0] sel,
  output logic          sel_purge
);
  logic [N-1:0] want;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_want
      assign want[g] = rd[g] | pg[g];
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) sel = IW'(i);
    end
  end

  assign any       = |want;
  assign sel_purge = pg[sel];
endmodule

// File: rtl/slist_entry.sv
module slist_entry
  import slist_pkg::*;
#(
  parameter int N  = 4,
  localparam int PW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ent_op_e       op,
  input  logic [PW-1:0] arg,
  output ent_state_e    state,
  output logic [PW-1:0] fwd,
  output logic [PW-1:0] bwd
);
  localparam logic [PW-1:0] NULLP = PW'(N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_INV;
      fwd   <= NULLP;
      bwd   <= NULLP;
    end else begin
      case (op)
        OP_MKHEAD: begin
          state <= ST_HEAD;
          fwd   <= arg;
          bwd   <= NULLP;
        end
        OP_PREPENDED: begin
          state <= demote_on_prepend(state, fwd != NULLP);
          bwd   <= arg;
        end
        OP_INVAL: begin
          state <= ST_INV;
          fwd   <= NULLP;
          bwd   <= NULLP;
        end
        OP_EXCL: begin
          state <= ST_EXCL;
          fwd   <= NULLP;
          bwd   <= NULLP;
        end
        default: ;
      endcase
    end
  end

  // R6
  inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_INVAL |=> state == ST_INV && fwd == NULLP && bwd == NULLP);

  // R4
  prepend_demotes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_PREPENDED |=> (state == ST_MID || state == ST_TAIL) && bwd == $past(arg));
endmodule

// File: rtl/slist_ctrl.sv
module slist_ctrl
  import slist_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int PW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_any,
  input  logic [IW-1:0] acc_sel,
  input  logic          acc_purge,
  input  ent_state_e    ent_state [N],
  input  logic [PW-1:0] ent_fwd   [N],
  output ent_op_e       op        [N],
  output logic [PW-1:0] arg       [N],
  output logic          mem_cached,
  output logic [PW-1:0] mem_head,
  output logic          done,
  output logic          err
);
  localparam logic [PW-1:0] NULLP = PW'(N);

  eng_fsm_e      fsm, fsm_n;
  logic [IW-1:0] req, req_n;
  logic [PW-1:0] oldh, oldh_n, cur, cur_n, head_n;
  logic          cached_n, fin, fin_err;

  // named internal events for the checks
  logic ev_accept, ev_prepend, ev_inval;
  assign ev_accept  = (fsm == F_IDLE) && acc_any;
  assign ev_prepend = (fsm == F_PREP);
  assign ev_inval   = (fsm == F_WALK);

  always_comb begin
    fsm_n    = fsm;
    req_n    = req;
    oldh_n   = oldh;
    cur_n    = cur;
    cached_n = mem_cached;
    head_n   = mem_head;
    fin      = 1'b0;
    fin_err  = 1'b0;
    for (int i = 0; i < N; i++) begin
      op[i]  = OP_NONE;
      arg[i] = NULLP;
    end
    case (fsm)
      F_IDLE: begin
        if (acc_any) begin
          req_n = acc_sel;
          fsm_n = acc_purge ? F_PCHK : F_RD;
        end
      end
      F_RD: begin
        if (ent_state[req] != ST_INV) begin
          fin   = 1'b1;
          fsm_n = F_IDLE;
        end else if (!mem_cached) begin
          op[req]  = OP_MKHEAD;
          arg[req] = NULLP;
          cached_n = 1'b1;
          head_n   = PW'(req);
          fin      = 1'b1;
          fsm_n    = F_IDLE;
        end else begin
          oldh_n = mem_head;
          fsm_n  = F_PREP;
        end
      end
      F_PREP: begin
        op[req]            = OP_MKHEAD;
        arg[req]           = oldh;
        op[oldh[IW-1:0]]   = OP_PREPENDED;
        arg[oldh[IW-1:0]]  = PW'(req);
        head_n             = PW'(req);
        fin                = 1'b1;
        fsm_n              = F_IDLE;
      end
      F_PCHK: begin
        if (ent_state[req] == ST_EXCL) begin
          fin   = 1'b1;
          fsm_n = F_IDLE;
        end else if (ent_state[req] != ST_HEAD) begin
          fin     = 1'b1;
          fin_err = 1'b1;
          fsm_n   = F_IDLE;
        end else if (ent_fwd[req] == NULLP) begin
          op[req] = OP_EXCL;
          fin     = 1'b1;
          fsm_n   = F_IDLE;
        end else begin
          cur_n = ent_fwd[req];
          fsm_n = F_WALK;
        end
      end
      F_WALK: begin
        op[cur[IW-1:0]] = OP_INVAL;
        if (ent_fwd[cur[IW-1:0]] == NULLP) begin
          op[req] = OP_EXCL;
          fin     = 1'b1;
          fsm_n   = F_IDLE;
        end else begin
          cur_n = ent_fwd[cur[IW-1:0]];
        end
      end
      default: fsm_n = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm        <= F_IDLE;
      req        <= '0;
      oldh       <= NULLP;
      cur        <= NULLP;
      mem_cached <= 1'b0;
      mem_head   <= NULLP;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      fsm        <= fsm_n;
      req        <= req_n;
      oldh       <= oldh_n;
      cur        <= cur_n;
      mem_cached <= cached_n;
      mem_head   <= head_n;
      done       <= fin;
      err        <= fin_err;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R3
  prep_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_prepend |=> mem_head == PW'($past(req)));

  // R6
  cached_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cached |=> mem_cached);

  // R9
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> fsm != F_IDLE && !done);

  // R6
  walk_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inval |-> cur != PW'(req) && cur != NULLP);
endmodule

// File: rtl/slist_engine.sv
module slist_engine
  import slist_pkg::*;
#(
  parameter int N_CACHE = 4
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [N_CACHE-1:0]                   rd_req,
  input  logic [N_CACHE-1:0]                   purge_req,
  output logic [3*N_CACHE-1:0]                 cache_state,
  output logic [$clog2(N_CACHE+1)*N_CACHE-1:0] cache_fwd,
  output logic [$clog2(N_CACHE+1)*N_CACHE-1:0] cache_bwd,
  output logic                                 mem_cached,
  output logic [$clog2(N_CACHE+1)-1:0]         mem_head,
  output logic                                 done,
  output logic                                 err
);
  localparam int IW = (N_CACHE > 1) ? $clog2(N_CACHE) : 1;
  localparam int PW = $clog2(N_CACHE + 1);

  logic          acc_any, acc_purge;
  logic [IW-1:0] acc_sel;
  ent_state_e    ent_state [N_CACHE];
  logic [PW-1:0] ent_fwd   [N_CACHE];
  logic [PW-1:0] ent_bwd   [N_CACHE];
  ent_op_e       ent_op    [N_CACHE];
  logic [PW-1:0] ent_arg   [N_CACHE];
  logic [N_CACHE-1:0] owner;

  slist_arb #(.N(N_CACHE)) u_arb (
    .rd(rd_req), .pg(purge_req),
    .any(acc_any), .sel(acc_sel), .sel_purge(acc_purge)
  );

  slist_ctrl #(.N(N_CACHE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .acc_any(acc_any), .acc_sel(acc_sel), .acc_purge(acc_purge),
    .ent_state(ent_state), .ent_fwd(ent_fwd),
    .op(ent_op), .arg(ent_arg),
    .mem_cached(mem_cached), .mem_head(mem_head),
    .done(done), .err(err)
  );

  genvar g;
  generate
    for (g = 0; g < N_CACHE; g++) begin : g_ent
      slist_entry #(.N(N_CACHE)) u_ent (
        .clk(clk), .rst_n(rst_n),
        .op(ent_op[g]), .arg(ent_arg[g]),
        .state(ent_state[g]), .fwd(ent_fwd[g]), .bwd(ent_bwd[g])
      );
      assign cache_state[3*g +: 3]  = ent_state[g];
      assign cache_fwd[PW*g +: PW]  = ent_fwd[g];
      assign cache_bwd[PW*g +: PW]  = ent_bwd[g];
      assign owner[g]               = is_owner(ent_state[g]);
    end
  endgenerate

  // R10
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));

  // R1
  uncached_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cached |-> owner == '0 && mem_head == PW'(N_CACHE));
endmodule

// File: tb/tb_slist_engine.sv
module tb_slist_engine;
  localparam int N = 4;
  localparam int PW = 3;
  localparam int NUL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rd_req = '0;
  logic [N-1:0] purge_req = '0;
  logic [3*N-1:0] cache_state;
  logic [PW*N-1:0] cache_fwd, cache_bwd;
  logic mem_cached;
  logic [PW-1:0] mem_head;
  logic done, err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model
  int e_st[N];
  int e_fw[N];
  int e_bw[N];
  int e_cached, e_head, e_done, e_err;

  always #4 clk = ~clk;

  slist_engine #(.N_CACHE(N)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .purge_req(purge_req),
    .cache_state(cache_state), .cache_fwd(cache_fwd), .cache_bwd(cache_bwd),
    .mem_cached(mem_cached), .mem_head(mem_head), .done(done), .err(err)
  );

  task automatic compare(input string rq);
    string msg;
    msg = "";
    total++;
    for (int i = 0; i < N; i++) begin
      if (int'(cache_state[3*i +: 3]) != e_st[i])
        msg = {msg, $sformatf(" c%0d.state actual=%0d expected=%0d", i, cache_state[3*i +: 3], e_st[i])};
      if (int'(cache_fwd[PW*i +: PW]) != e_fw[i])
        msg = {msg, $sformatf(" c%0d.fwd actual=%0d expected=%0d", i, cache_fwd[PW*i +: PW], e_fw[i])};
      if (int'(cache_bwd[PW*i +: PW]) != e_bw[i])
        msg = {msg, $sformatf(" c%0d.bwd actual=%0d expected=%0d", i, cache_bwd[PW*i +: PW], e_bw[i])};
    end
    if (int'(mem_cached) != e_cached)
      msg = {msg, $sformatf(" cached actual=%0d expected=%0d", mem_cached, e_cached)};
    if (int'(mem_head) != e_head)
      msg = {msg, $sformatf(" head actual=%0d expected=%0d", mem_head, e_head)};
    if (int'(done) != e_done)
      msg = {msg, $sformatf(" done actual=%0d expected=%0d", done, e_done)};
    if (int'(err) != e_err)
      msg = {msg, $sformatf(" err actual=%0d expected=%0d", err, e_err)};
    if (msg != "") begin
      bad++;
      $display("FAIL %s at %0t:%s", rq, $time, msg);
    end
  endtask

  task automatic tick(input string rq);
    @(posedge clk);
    #2;
    compare(rq);
  endtask

  // One transaction: rd/pg drive the accept cycle, noise is driven during the first busy cycle.
  task automatic txn(input logic [N-1:0] rd, input logic [N-1:0] pg,
                     input logic [N-1:0] noise, input string rq);
    int w;
    w = -1;
    for (int i = N - 1; i >= 0; i--) if (rd[i] || pg[i]) w = i;
    rd_req = rd; purge_req = pg;
    e_done = 0; e_err = 0;
    tick(rq);                                  // accept edge
    rd_req = noise; purge_req = noise;         // R9: dropped while busy
    if (w < 0) begin
      rd_req = '0; purge_req = '0;
      return;
    end
    if (!pg[w]) begin
      if (e_st[w] != 0) begin                  // R5
        e_done = 1;
        tick(rq);
      end else if (e_cached == 0) begin        // R2
        e_st[w] = 1; e_fw[w] = NUL; e_bw[w] = NUL;
        e_cached = 1; e_head = w; e_done = 1;
        tick(rq);
      end else begin                           // R3 / R4
        int h;
        tick(rq);
        rd_req = '0; purge_req = '0;
        h = e_head;
        e_st[h] = (e_st[h] == 1 && e_fw[h] != NUL) ? 2 : 3;
        e_bw[h] = w;
        e_st[w] = 1; e_fw[w] = h; e_bw[w] = NUL;
        e_head = w; e_done = 1;
        tick(rq);
      end
    end else begin
      if (e_st[w] == 4) begin                  // R8
        e_done = 1;
        tick(rq);
      end else if (e_st[w] != 1) begin         // R7
        e_done = 1; e_err = 1;
        tick(rq);
      end else if (e_fw[w] == NUL) begin       // R6 lone head
        e_st[w] = 4; e_done = 1;
        tick(rq);
      end else begin                           // R6 walk
        int cur;
        tick(rq);
        rd_req = '0; purge_req = '0;
        cur = e_fw[w];
        forever begin
          int nxt;
          nxt = e_fw[cur];
          e_st[cur] = 0; e_fw[cur] = NUL; e_bw[cur] = NUL;
          if (nxt == NUL) begin
            e_st[w] = 4; e_fw[w] = NUL; e_bw[w] = NUL; e_done = 1;
            tick(rq);
            break;
          end
          tick(rq);
          cur = nxt;
        end
      end
    end
    rd_req = '0; purge_req = '0;
    e_done = 0; e_err = 0;
    tick("R10");                               // pulses must drop
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin e_st[i] = 0; e_fw[i] = NUL; e_bw[i] = NUL; end
    e_cached = 0; e_head = NUL; e_done = 0; e_err = 0;
    repeat (3) @(posedge clk);
    #2 compare("R1");                          // R1 during reset
    rst_n = 1'b1;
    tick("R1");

    txn(4'b0001, 4'b0000, 4'b0000, "R2");      // first fill by cache 0
    txn(4'b0100, 4'b0000, 4'b0000, "R3");      // prepend onto lone head -> tail (R4)
    txn(4'b0010, 4'b0000, 4'b1111, "R4");      // prepend onto head with successor -> middle, noise R9
    txn(4'b0100, 4'b0000, 4'b0000, "R5");      // read hit from middle
    txn(4'b0000, 4'b0001, 4'b0000, "R7");      // purge from tail rejected
    txn(4'b0000, 4'b0010, 4'b0000, "R6");      // head 1 purges 2 then 0
    txn(4'b0000, 4'b0010, 4'b0000, "R8");      // purge from exclusive
    txn(4'b1000, 4'b0000, 4'b0000, "R4");      // prepend onto exclusive -> tail
    txn(4'b0110, 4'b0010, 4'b0000, "R9");      // cache 1 purge wins over its read and cache 2
    txn(4'b1001, 4'b0000, 4'b0000, "R9");      // cache 0 read wins over cache 3
    txn(4'b0000, 4'b0001, 4'b0110, "R6");      // head 0 walks 3 then 1
    txn(4'b0100, 4'b0000, 4'b0000, "R4");      // prepend onto exclusive
    txn(4'b0000, 4'b0100, 4'b0000, "R6");      // two-entry purge
    txn(4'b0000, 4'b0100, 4'b0000, "R8");
    txn(4'b0000, 4'b1000, 4'b0000, "R7");      // invalid cache purge rejected
    repeat (2) tick("R10");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule